// File: doc/BRIEF.md
# Big-Endian Load/Store Byte-Lane Unit

This block sits between a processor core and a data memory that is one word wide and addressed in bytes. It takes no part in address arithmetic or memory timing. It only maps an access of byte, halfword or word size onto the four byte lanes of the memory word, using big-endian lane order. In that order the byte at the lowest address of a word occupies the most significant bits.

On the write side, the block takes the access size, the two low address bits and the register value. It produces one write strobe per byte lane and a write word in which the register value has been copied across the lanes. On the read side, it picks the addressed byte or halfword out of the memory word and widens it to the full data width, by sign extension or zero extension. Any access whose address does not match its size raises a fault flag. A faulting access writes nothing and reads back zero.

The logic is purely combinational, and all outputs follow the inputs in the same cycle.

Top module: `bels_lane_unit`

## Requirements
- R1: A byte store at offset k (addr_lo = k) asserts only byte_we[3-k]. Strobe bit j enables data bits 8j+7..8j, so offset 0 writes bits 31..24.
- R2: An aligned halfword store asserts byte_we = 4'b1100 at offset 0 and byte_we = 4'b0011 at offset 2.
- R3: A word store at offset 0 asserts byte_we = 4'b1111.
- R4: The write word copies the low byte of st_data into all four lanes for a byte access, copies the low halfword into both halves for a halfword access, and passes st_data through unchanged for a word access or for size code 2'b11.
- R5: When is_store is 0, byte_we is 4'b0000 for every size and offset.
- R6: Size codes are 2'b00 byte, 2'b01 halfword, 2'b10 word and 2'b11 reserved. The fault flag is high for a halfword with addr_lo[0] = 1, for a word with addr_lo != 0, and for the reserved code. It is never high for a byte access. While the flag is high, byte_we is 4'b0000.
- R7: A byte load at offset k returns mem_rdata bits 31-8k..24-8k in bits 7..0 of ld_result.
- R8: A halfword load returns mem_rdata bits 31..16 at offset 0 and bits 15..0 at offset 2, in bits 15..0 of ld_result.
- R9: With ld_signed = 1, a byte or halfword load copies the top bit of the selected data into every upper bit (byte 0xF7 gives 0xFFFFFFF7).
- R10: With ld_signed = 0, a byte or halfword load fills the upper bits with zero (byte 0xF7 gives 0x000000F7).
- R11: While the fault flag is high, ld_result is zero.
- R12: An aligned word load returns mem_rdata unchanged, whatever ld_signed is.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| acc_size | input | 2 | Access size: 00 byte, 01 halfword, 10 word, 11 reserved |
| addr_lo | input | 2 | Byte offset of the access within the word |
| is_store | input | 1 | High for a store, low for a load |
| ld_signed | input | 1 | Sign-extend (1) or zero-extend (0) sub-word loads |
| st_data | input | 32 | Register value to be stored |
| mem_rdata | input | 32 | Word read from memory |
| byte_we | output | 4 | Per-lane write strobes, bit 3 = bits 31..24 |
| mem_wdata | output | 32 | Lane-replicated write word |
| ld_result | output | 32 | Extracted and extended load value |
| misaligned | output | 1 | Access offset does not fit the access size |

## Verification
The hardest case to bring about is one where the two extension rules can be told apart and a wrong lane choice still stands out. Both need a selected byte or halfword whose top bit is set, while the neighbouring lanes hold different values. The stimulus therefore sweeps every size, offset, signedness and direction against read words in which each byte differs from the others and several bytes have their top bit set. This includes the reserved size code and the faulting offsets, so that the fault flag's suppression of strobes and of load data is exercised on both paths.

// File: rtl/bels_pkg.sv
package bels_pkg;

  localparam int unsigned BYTE_W = 8;

  typedef enum logic [1:0] {
    ACC_BYTE = 2'b00,
    ACC_HALF = 2'b01,
    ACC_WORD = 2'b10,
    ACC_RSVD = 2'b11
  } acc_size_e;

endpackage

// File: rtl/bels_align_chk.sv
module bels_align_chk
  import bels_pkg::*;
#(
  parameter int OFF_W = 2
) (
  input  acc_size_e        size,
  input  logic [OFF_W-1:0] off,
  output logic             fault
);

  // A halfword needs an even offset; a word needs offset zero.
  always_comb begin
    case (size)
      ACC_BYTE: fault = 1'b0;
      ACC_HALF: fault = off[0];
      ACC_WORD: fault = |off;
      default:  fault = 1'b1;
    endcase
  end

endmodule

// File: rtl/bels_store_lanes.sv
module bels_store_lanes
  import bels_pkg::*;
#(
  parameter  int DATA_W = 32,
  localparam int LANES  = DATA_W / BYTE_W,
  localparam int OFF_W  = $clog2(LANES)
) (
  input  acc_size_e         size,
  input  logic [OFF_W-1:0]  off,
  input  logic              wr_req,
  input  logic              fault,
  input  logic [DATA_W-1:0] wdata_in,
  output logic [LANES-1:0]  we,
  output logic [DATA_W-1:0] wdata
);

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    // Strobe bit g covers the byte that sits at offset LANES-1-g.
    localparam int BYTE_OFF  = LANES - 1 - g;
    localparam int HALF_IDX  = BYTE_OFF / 2;
    localparam int HALF_BYTE = g % 2;

    logic                hit;
    logic [BYTE_W-1:0]   lane_d;

    always_comb begin
      case (size)
        ACC_BYTE: hit = (off == BYTE_OFF[OFF_W-1:0]);
        ACC_HALF: hit = (off[OFF_W-1:1] == HALF_IDX[OFF_W-2:0]);
        ACC_WORD: hit = 1'b1;
        default:  hit = 1'b0;
      endcase
    end

    always_comb begin
      case (size)
        ACC_BYTE: lane_d = wdata_in[BYTE_W-1:0];
        ACC_HALF: lane_d = wdata_in[HALF_BYTE*BYTE_W +: BYTE_W];
        default:  lane_d = wdata_in[g*BYTE_W +: BYTE_W];
      endcase
    end

    assign we[g]                    = wr_req & ~fault & hit;
    assign wdata[g*BYTE_W +: BYTE_W] = lane_d;
  end

endmodule

// File: rtl/bels_load_extract.sv
module bels_load_extract
  import bels_pkg::*;
#(
  parameter  int DATA_W = 32,
  localparam int LANES  = DATA_W / BYTE_W,
  localparam int HALVES = LANES / 2,
  localparam int HALF_W = 2 * BYTE_W,
  localparam int OFF_W  = $clog2(LANES)
) (
  input  acc_size_e         size,
  input  logic [OFF_W-1:0]  off,
  input  logic              sx,
  input  logic              fault,
  input  logic [DATA_W-1:0] rdata,
  output logic [DATA_W-1:0] result
);

  function automatic logic [DATA_W-1:0] widen_byte(input logic [BYTE_W-1:0] b,
                                                   input logic sgn);
    return {{(DATA_W-BYTE_W){sgn & b[BYTE_W-1]}}, b};
  endfunction

  function automatic logic [DATA_W-1:0] widen_half(input logic [HALF_W-1:0] h,
                                                   input logic sgn);
    return {{(DATA_W-HALF_W){sgn & h[HALF_W-1]}}, h};
  endfunction

  // Big-endian views: index 0 is the most significant byte / halfword.
  logic [BYTE_W-1:0] be_bytes  [LANES];
  logic [HALF_W-1:0] be_halves [HALVES];

  for (genvar g = 0; g < LANES; g++) begin : g_byte
    assign be_bytes[g] = rdata[DATA_W-1-g*BYTE_W -: BYTE_W];
  end

  for (genvar h = 0; h < HALVES; h++) begin : g_half
    assign be_halves[h] = rdata[DATA_W-1-h*HALF_W -: HALF_W];
  end

  logic [BYTE_W-1:0] byte_pick;
  logic [HALF_W-1:0] half_pick;

  assign byte_pick = be_bytes[off];
  assign half_pick = be_halves[off[OFF_W-1:1]];

  always_comb begin
    if (fault) begin
      result = '0;
    end else begin
      case (size)
        ACC_BYTE: result = widen_byte(byte_pick, sx);
        ACC_HALF: result = widen_half(half_pick, sx);
        default:  result = rdata;
      endcase
    end
  end

endmodule

// File: rtl/bels_lane_unit.sv
module bels_lane_unit
  import bels_pkg::*;
#(
  parameter  int DATA_W = 32,
  localparam int LANES  = DATA_W / BYTE_W,
  localparam int OFF_W  = $clog2(LANES)
) (
  input  logic [1:0]        acc_size,
  input  logic [OFF_W-1:0]  addr_lo,
  input  logic              is_store,
  input  logic              ld_signed,
  input  logic [DATA_W-1:0] st_data,
  input  logic [DATA_W-1:0] mem_rdata,
  output logic [LANES-1:0]  byte_we,
  output logic [DATA_W-1:0] mem_wdata,
  output logic [DATA_W-1:0] ld_result,
  output logic              misaligned
);

  acc_size_e size_q;
  logic      align_fault;

  assign size_q = acc_size_e'(acc_size);

  bels_align_chk #(.OFF_W(OFF_W)) u_align (
    .size  (size_q),
    .off   (addr_lo),
    .fault (align_fault)
  );

  bels_store_lanes #(.DATA_W(DATA_W)) u_store (
    .size     (size_q),
    .off      (addr_lo),
    .wr_req   (is_store),
    .fault    (align_fault),
    .wdata_in (st_data),
    .we       (byte_we),
    .wdata    (mem_wdata)
  );

  bels_load_extract #(.DATA_W(DATA_W)) u_load (
    .size   (size_q),
    .off    (addr_lo),
    .sx     (ld_signed),
    .fault  (align_fault),
    .rdata  (mem_rdata),
    .result (ld_result)
  );

  assign misaligned = align_fault;

endmodule

// File: rtl/bels_lane_unit_sva.sv
module bels_lane_unit_sva #(
  parameter  int DATA_W = 32,
  localparam int LANES  = DATA_W / 8,
  localparam int OFF_W  = $clog2(LANES)
) (
  input logic [1:0]        acc_size,
  input logic [OFF_W-1:0]  addr_lo,
  input logic              is_store,
  input logic              ld_signed,
  input logic [DATA_W-1:0] ld_result,
  input logic [LANES-1:0]  byte_we,
  input logic              align_fault
);

  always_comb begin
    if (align_fault) begin
      assert_fault_no_we_R6: assert (byte_we == '0)
        else $error("strobe active during fault");
      assert_fault_zero_load_R11: assert (ld_result == '0)
        else $error("load data during fault");
    end
    if (acc_size == 2'b00) begin
      assert_byte_never_faults_R6: assert (!align_fault)
        else $error("byte access flagged");
    end
    if (!is_store) begin
      assert_load_no_we_R5: assert (byte_we == '0)
        else $error("strobe active on load");
    end
    if (is_store && acc_size == 2'b00) begin
      assert_byte_one_lane_R1: assert ($countones(byte_we) == 1)
        else $error("byte store lane count");
    end
    if (is_store && acc_size == 2'b01 && !align_fault) begin
      assert_half_two_lanes_R2: assert ($countones(byte_we) == 2)
        else $error("halfword store lane count");
    end
    if (is_store && acc_size == 2'b10 && !align_fault) begin
      assert_word_all_lanes_R3: assert (&byte_we)
        else $error("word store lanes");
    end
    if (acc_size == 2'b00 && !align_fault && ld_signed) begin
      assert_byte_sign_fill_R9: assert (ld_result[DATA_W-1:8] == (ld_result[7] ? '1 : '0))
        else $error("signed byte fill");
    end
    if (acc_size == 2'b00 && !align_fault && !ld_signed) begin
      assert_byte_zero_fill_R10: assert (ld_result[DATA_W-1:8] == '0)
        else $error("unsigned byte fill");
    end
  end

endmodule

bind bels_lane_unit bels_lane_unit_sva #(.DATA_W(DATA_W)) u_sva (
  .acc_size    (acc_size),
  .addr_lo     (addr_lo),
  .is_store    (is_store),
  .ld_signed   (ld_signed),
  .ld_result   (ld_result),
  .byte_we     (byte_we),
  .align_fault (align_fault)
);

// File: tb/bels_lane_unit_bench.sv
module bels_lane_unit_bench;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [1:0]  acc_size;
  logic [1:0]  addr_lo;
  logic        is_store;
  logic        ld_signed;
  logic [31:0] st_data;
  logic [31:0] mem_rdata;
  logic [3:0]  byte_we;
  logic [31:0] mem_wdata;
  logic [31:0] ld_result;
  logic        misaligned;

  int n_run  = 0;
  int n_fail = 0;
  bit done   = 0;

  always #2.5 clk = ~clk;

  bels_lane_unit u_bels_lane_unit (
    .acc_size   (acc_size),
    .addr_lo    (addr_lo),
    .is_store   (is_store),
    .ld_signed  (ld_signed),
    .st_data    (st_data),
    .mem_rdata  (mem_rdata),
    .byte_we    (byte_we),
    .mem_wdata  (mem_wdata),
    .ld_result  (ld_result),
    .misaligned (misaligned)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: size=%0d off=%0d st=%0b sgn=%0b actual=%h expected=%h",
               req, acc_size, addr_lo, is_store, ld_signed, act, exp);
    end
  endtask

  // Behavioural reference: arithmetic on integers, shifts instead of lane muxes.
  task automatic compare_all();
    int          sz  = int'(acc_size);
    int          off = int'(addr_lo);
    bit          bad;
    logic [3:0]  e_we;
    logic [31:0] e_wd, e_ld, v;
    string       t_we, t_ld;

    bad = (sz == 3) || (sz == 1 && (off % 2) == 1) || (sz == 2 && off != 0);

    if (!is_store || bad) e_we = 4'h0;
    else if (sz == 0)     e_we = 4'(1 << (3 - off));
    else if (sz == 1)     e_we = (off < 2) ? 4'hC : 4'h3;
    else                  e_we = 4'hF;

    if (sz == 0)      e_wd = {4{st_data[7:0]}};
    else if (sz == 1) e_wd = {2{st_data[15:0]}};
    else              e_wd = st_data;

    if (bad) e_ld = 32'h0;
    else if (sz == 0) begin
      v = (mem_rdata >> (8 * (3 - off))) & 32'hFF;
      e_ld = (ld_signed && v[7]) ? (v | 32'hFFFF_FF00) : v;
    end else if (sz == 1) begin
      v = (mem_rdata >> (16 * (1 - off / 2))) & 32'hFFFF;
      e_ld = (ld_signed && v[15]) ? (v | 32'hFFFF_0000) : v;
    end else e_ld = mem_rdata;

    if (!is_store) t_we = "R5";
    else if (bad)  t_we = "R6";
    else if (sz == 0) t_we = "R1";
    else if (sz == 1) t_we = "R2";
    else t_we = "R3";

    if (bad) t_ld = "R11";
    else if (sz == 0) t_ld = ld_signed ? "R7/R9" : "R7/R10";
    else if (sz == 1) t_ld = ld_signed ? "R8/R9" : "R8/R10";
    else t_ld = "R12";

    check(t_we, {28'h0, byte_we}, {28'h0, e_we});
    check("R4", mem_wdata, e_wd);
    check("R6", {31'h0, misaligned}, {31'h0, bad});
    check(t_ld, ld_result, e_ld);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    logic [31:0] pats [4];
    pats[0] = 32'hF7A5_1C80;
    pats[1] = 32'h1234_5678;
    pats[2] = 32'h807F_01FE;
    pats[3] = 32'hC3E1_5A96;

    acc_size = 2'b00; addr_lo = 2'b00; is_store = 1'b0; ld_signed = 1'b0;
    st_data = 32'h0; mem_rdata = 32'h0;
    repeat (3) @(posedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // Quiet state after reset: no strobes, zero data (R5).
    check("R5", {28'h0, byte_we}, 32'h0);
    check("R6", {31'h0, misaligned}, 32'h0);
    check("R10", ld_result, 32'h0);

    for (int p = 0; p < 4; p++) begin
      for (int sz = 0; sz < 4; sz++) begin
        for (int off = 0; off < 4; off++) begin
          for (int sg = 0; sg < 2; sg++) begin
            for (int st = 0; st < 2; st++) begin
              @(posedge clk);
              acc_size  = 2'(sz);
              addr_lo   = 2'(off);
              ld_signed = 1'(sg);
              is_store  = 1'(st);
              mem_rdata = pats[p];
              st_data   = pats[3 - p] ^ 32'h0F0F_0F0F;
              @(negedge clk);
              compare_all();
            end
          end
        end
      end
    end

    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

endmodule